// File: doc/BRIEF.md
# Lockable Control Register Bank

This block is a small byte-addressed register bank that sits behind the control-register identity of a two-wire serial slave. The bit-level front end decodes the slave byte and then tells the bank that a transaction has begun, and in which direction. It passes the bytes that follow as a valid/ready stream.

In a write transaction, the first byte loads an internal register pointer. Every later byte is stored at that pointer, and the pointer then advances. In a read transaction, the bank streams out the byte at the pointer and advances after each accepted byte. A random read is therefore done as a write transaction that carries only the address byte, followed by a read transaction.

The bank holds three kinds of register:
- A control byte whose bits drive the memory-protection logic elsewhere in the chip.
- An eight-byte serial number that software can program.
- A four-byte identifier fixed by a parameter.

Setting a lock bit in the control byte freezes the serial number until the next reset.

Both streams use valid/ready handshakes. On the write stream, `wr_ready` is high only while a write transaction is open. A byte offered outside a write transaction simply waits. On the read stream, `rd_valid` is high throughout an open read transaction. `rd_data` holds its value, and the pointer holds, until the consumer raises `rd_ready`. Both handshake signals are forced low in any cycle where `txn_start` or `txn_stop` is asserted. No byte moves in such a cycle.

Top module: `ctlreg_bank`

## Requirements
- R1: After reset, the control byte and all serial bytes are 0x00 and the pointer is 0x00. No transaction is open, so `wr_ready` and `rd_valid` are both 0.
- R2: The first byte accepted after a `txn_start` with `txn_read`=0 loads the pointer. It changes no register.
- R3: Each later accepted write byte is stored at the pointer address when that address is writable. The pointer then advances by one.
- R4: During a read transaction, `rd_valid` is 1 and `rd_data` shows the byte at the pointer. The pointer advances by one on each cycle with `rd_valid` and `rd_ready` both high. While `rd_ready` is low, `rd_data` is stable.
- R5: Address 0x00 is the control byte. It can be read and written, and it is driven continuously on `mem_ctrl`.
- R6: The lock flag is bit 6 of the control byte (parameter `LOCK_BIT`). Once it is 1, writing 0 to that bit leaves it at 1 until reset. The other control bits stay writable.
- R7: Addresses 0x01 to 0x08 hold the serial number. Writes there take effect only while the lock flag is 0. Otherwise the byte is accepted and discarded.
- R8: Addresses 0x09 to 0x0C return the identifier parameter `DEV_ID`, most significant byte at 0x09. Writes to them are accepted and discarded.
- R9: Addresses 0x0D to 0xFF are reserved. They read 0x00, and writes to them are accepted and discarded.
- R10: The pointer saturates at 0xFF. Advancing from 0xFF leaves it at 0xFF and never wraps to 0x00.
- R11: `wr_ready` is 1 only during an open write transaction and `rd_valid` only during an open read transaction. Both are 0 in a cycle with `txn_start` or `txn_stop`, and a stop closes the transaction.
- R12: The pointer is kept across transactions. A read transaction starts at the address the previous transaction left.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Pulse: the slave byte matched, a transaction opens |
| txn_read | input | 1 | Direction qualifying `txn_start`: 1 read, 0 write |
| txn_stop | input | 1 | Pulse: the transaction closes |
| wr_valid | input | 1 | Write byte offered |
| wr_data | input | 8 | Write byte (address byte first, then data) |
| wr_ready | output | 1 | Bank accepts the write byte |
| rd_valid | output | 1 | Read byte available |
| rd_data | output | 8 | Byte at the current pointer |
| rd_ready | input | 1 | Consumer takes the read byte |
| mem_ctrl | output | 8 | Current control byte, including protection bits and lock flag |

## Verification
A pointer that loads or advances wrongly shows up on the very next accepted read byte, because `rd_data` is a direct view of the pointed register. A byte stored to the wrong address, or stored despite the lock, stays hidden until that address is read back. The bench therefore re-reads every region after each write pattern. A wrongly cleared lock flag appears on `mem_ctrl` one cycle after the offending write. The saturation rule becomes visible only on the second read past 0xFF, where a wrap would expose the control byte.

// File: rtl/ctlreg_pkg.sv
package ctlreg_pkg;

  localparam int PTR_W     = 8;
  localparam int BYTE_W    = 8;
  localparam int CTRL_ADDR = 0;
  localparam int SN_LO     = 1;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_WR   = 2'd1,
    MODE_RD   = 2'd2
  } mode_e;

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == {PTR_W{1'b1}}) ? p : p + 1'b1;
  endfunction

endpackage

// File: rtl/ctlreg_seq.sv
module ctlreg_seq
  import ctlreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              txn_read,
  input  logic              txn_stop,
  input  logic              wr_valid,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_ready,
  output logic              wr_ready,
  output logic              rd_valid,
  output logic              data_we,
  output logic [PTR_W-1:0]  ptr
);

  mode_e mode_q;
  logic  addr_pending_q;
  logic  edge_cycle;
  logic  wr_fire;
  logic  rd_fire;

  assign edge_cycle = txn_start | txn_stop;
  assign wr_ready   = (mode_q == MODE_WR) && !edge_cycle;
  assign rd_valid   = (mode_q == MODE_RD) && !edge_cycle;
  assign wr_fire    = wr_valid && wr_ready;
  assign rd_fire    = rd_valid && rd_ready;
  assign data_we    = wr_fire && !addr_pending_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q         <= MODE_IDLE;
      addr_pending_q <= 1'b0;
      ptr            <= '0;
    end else if (txn_start) begin
      mode_q         <= txn_read ? MODE_RD : MODE_WR;
      addr_pending_q <= !txn_read;
    end else if (txn_stop) begin
      mode_q         <= MODE_IDLE;
      addr_pending_q <= 1'b0;
    end else if (wr_fire) begin
      if (addr_pending_q) begin
        ptr            <= wr_data;
        addr_pending_q <= 1'b0;
      end else begin
        ptr <= ptr_next(ptr);
      end
    end else if (rd_fire) begin
      ptr <= ptr_next(ptr);
    end
  end

endmodule

// File: rtl/ctlreg_store.sv
module ctlreg_store
  import ctlreg_pkg::*;
#(
  parameter int SN_BYTES = 8,
  parameter int LOCK_BIT = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [PTR_W-1:0]           ptr,
  input  logic [BYTE_W-1:0]          wdata,
  output logic [BYTE_W-1:0]          ctrl_q,
  output logic [SN_BYTES*BYTE_W-1:0] sn_q
);

  localparam logic [BYTE_W-1:0] LOCK_MASK = BYTE_W'(1) << LOCK_BIT;

  logic locked;
  assign locked = ctrl_q[LOCK_BIT];

  // Control byte: the lock flag can only be set; clearing waits for reset.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q <= '0;
    end else if (we && ptr == PTR_W'(CTRL_ADDR)) begin
      ctrl_q <= wdata | (ctrl_q & LOCK_MASK);
    end
  end

  for (genvar g = 0; g < SN_BYTES; g++) begin : g_sn
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        sn_q[g*BYTE_W +: BYTE_W] <= '0;
      end else if (we && !locked && ptr == PTR_W'(SN_LO + g)) begin
        sn_q[g*BYTE_W +: BYTE_W] <= wdata;
      end
    end
  end

endmodule

// File: rtl/ctlreg_rdmux.sv
module ctlreg_rdmux
  import ctlreg_pkg::*;
#(
  parameter int SN_BYTES = 8,
  parameter int ID_BYTES = 4,
  parameter logic [ID_BYTES*BYTE_W-1:0] DEV_ID = '0
) (
  input  logic [PTR_W-1:0]           ptr,
  input  logic [BYTE_W-1:0]          ctrl_q,
  input  logic [SN_BYTES*BYTE_W-1:0] sn_q,
  output logic [BYTE_W-1:0]          rbyte
);

  localparam int ID_LO = SN_LO + SN_BYTES;

  // Anything not matched below is reserved and reads as zero.
  always_comb begin
    rbyte = '0;
    if (ptr == PTR_W'(CTRL_ADDR)) rbyte = ctrl_q;
    for (int i = 0; i < SN_BYTES; i++) begin
      if (ptr == PTR_W'(SN_LO + i)) rbyte = sn_q[i*BYTE_W +: BYTE_W];
    end
    for (int j = 0; j < ID_BYTES; j++) begin
      if (ptr == PTR_W'(ID_LO + j)) rbyte = DEV_ID[(ID_BYTES-1-j)*BYTE_W +: BYTE_W];
    end
  end

endmodule

// File: rtl/ctlreg_bank.sv
module ctlreg_bank
  import ctlreg_pkg::*;
#(
  parameter int SN_BYTES = 8,
  parameter int ID_BYTES = 4,
  parameter int LOCK_BIT = 6,
  parameter logic [ID_BYTES*8-1:0] DEV_ID = 32'hC35A1E07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_start,
  input  logic       txn_read,
  input  logic       txn_stop,
  input  logic       wr_valid,
  input  logic [7:0] wr_data,
  output logic       wr_ready,
  output logic       rd_valid,
  output logic [7:0] rd_data,
  input  logic       rd_ready,
  output logic [7:0] mem_ctrl
);

  logic                       data_we;
  logic [PTR_W-1:0]           ptr;
  logic [BYTE_W-1:0]          ctrl_q;
  logic [SN_BYTES*BYTE_W-1:0] sn_q;

  ctlreg_seq u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .txn_start (txn_start),
    .txn_read  (txn_read),
    .txn_stop  (txn_stop),
    .wr_valid  (wr_valid),
    .wr_data   (wr_data),
    .rd_ready  (rd_ready),
    .wr_ready  (wr_ready),
    .rd_valid  (rd_valid),
    .data_we   (data_we),
    .ptr       (ptr)
  );

  ctlreg_store #(.SN_BYTES(SN_BYTES), .LOCK_BIT(LOCK_BIT)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (data_we),
    .ptr    (ptr),
    .wdata  (wr_data),
    .ctrl_q (ctrl_q),
    .sn_q   (sn_q)
  );

  ctlreg_rdmux #(.SN_BYTES(SN_BYTES), .ID_BYTES(ID_BYTES), .DEV_ID(DEV_ID)) u_rdmux (
    .ptr    (ptr),
    .ctrl_q (ctrl_q),
    .sn_q   (sn_q),
    .rbyte  (rd_data)
  );

  assign mem_ctrl = ctrl_q;

endmodule

// File: rtl/ctlreg_bank_chk.sv
module ctlreg_bank_chk #(
  parameter int LOCK_BIT = 6
) (
  input logic       clk,
  input logic       rst_n,
  input logic       txn_start,
  input logic       txn_read,
  input logic       txn_stop,
  input logic       wr_valid,
  input logic       wr_ready,
  input logic       rd_valid,
  input logic       rd_ready,
  input logic [7:0] rd_data,
  input logic [7:0] mem_ctrl
);

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    mem_ctrl[LOCK_BIT] |=> mem_ctrl[LOCK_BIT]);

  p_ctrl_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_valid && wr_ready) |=> $stable(mem_ctrl));

  p_rd_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> $stable(rd_data));

  p_open_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_start && txn_read) |=> (!wr_ready && (rd_valid || txn_start || txn_stop)));

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_ready && rd_valid));

  p_stop_closes_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (txn_stop && !txn_start) |=> (!wr_ready && !rd_valid));

endmodule

bind ctlreg_bank ctlreg_bank_chk #(.LOCK_BIT(LOCK_BIT)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .txn_start (txn_start),
  .txn_read  (txn_read),
  .txn_stop  (txn_stop),
  .wr_valid  (wr_valid),
  .wr_ready  (wr_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .mem_ctrl  (mem_ctrl)
);

// File: tb/ctlreg_bank_bench.sv
`timescale 1ns/1ps
module ctlreg_bank_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       txn_start = 1'b0, txn_read = 1'b0, txn_stop = 1'b0;
  logic       wr_valid = 1'b0, rd_ready = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready, rd_valid;
  logic [7:0] rd_data, mem_ctrl;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  ctlreg_bank u_ctlreg_bank (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .txn_read(txn_read),
    .txn_stop(txn_stop), .wr_valid(wr_valid), .wr_data(wr_data),
    .wr_ready(wr_ready), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_ready(rd_ready), .mem_ctrl(mem_ctrl)
  );

  localparam logic [2:0] OP_SW = 3'd0, OP_SR = 3'd1, OP_W = 3'd2, OP_R = 3'd3, OP_SP = 3'd4;
  localparam int NVEC = 48;
  // {op, byte (write data or expected read data), requirement index}
  localparam logic [14:0] VEC [NVEC] = '{
    {OP_SW,8'h00,4'd11}, {OP_W,8'h01,4'd2},
    {OP_W,8'h11,4'd7}, {OP_W,8'h22,4'd7}, {OP_W,8'h33,4'd7}, {OP_W,8'h44,4'd7},
    {OP_W,8'h55,4'd7}, {OP_W,8'h66,4'd7}, {OP_W,8'h77,4'd7}, {OP_W,8'h88,4'd7},
    {OP_W,8'hAB,4'd8}, {OP_SP,8'h00,4'd11},
    {OP_SW,8'h00,4'd11}, {OP_W,8'h00,4'd2}, {OP_SP,8'h00,4'd11},
    {OP_SR,8'h00,4'd12}, {OP_R,8'h00,4'd5},
    {OP_R,8'h11,4'd3}, {OP_R,8'h22,4'd3}, {OP_R,8'h33,4'd3}, {OP_R,8'h44,4'd3},
    {OP_R,8'h55,4'd7}, {OP_R,8'h66,4'd7}, {OP_R,8'h77,4'd7}, {OP_R,8'h88,4'd7},
    {OP_R,8'hC3,4'd8}, {OP_R,8'h5A,4'd8}, {OP_R,8'h1E,4'd8}, {OP_R,8'h07,4'd8},
    {OP_R,8'h00,4'd9}, {OP_SP,8'h00,4'd11},
    {OP_SW,8'h00,4'd11}, {OP_W,8'h00,4'd2}, {OP_W,8'h45,4'd5}, {OP_W,8'h99,4'd7},
    {OP_SP,8'h00,4'd11},
    {OP_SW,8'h00,4'd11}, {OP_W,8'h00,4'd2}, {OP_W,8'h05,4'd6}, {OP_SP,8'h00,4'd11},
    {OP_SW,8'h00,4'd11}, {OP_W,8'h00,4'd2}, {OP_SP,8'h00,4'd11},
    {OP_SR,8'h00,4'd12}, {OP_R,8'h45,4'd6}, {OP_R,8'h11,4'd7}, {OP_R,8'h22,4'd7},
    {OP_SP,8'h00,4'd11}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd5:  return "R5";
      4'd6:  return "R6";
      4'd7:  return "R7";
      4'd8:  return "R8";
      4'd9:  return "R9";
      4'd10: return "R10";
      4'd11: return "R11";
      default: return "R12";
    endcase
  endfunction

  task automatic chk(input string tag, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %02h expected %02h", tag, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic do_start(input logic rd);
    txn_start = 1'b1; txn_read = rd;
    #1;
    chk("R11", "handshakes low during start", {6'd0, wr_ready, rd_valid}, 8'h00);
    tick();
    txn_start = 1'b0; txn_read = 1'b0;
  endtask

  task automatic do_stop();
    txn_stop = 1'b1;
    tick();
    txn_stop = 1'b0;
    #1;
    chk("R11", "closed after stop", {6'd0, wr_ready, rd_valid}, 8'h00);
  endtask

  task automatic do_w(input logic [7:0] d, input string tag);
    wr_valid = 1'b1; wr_data = d;
    #1;
    chk(tag, "wr_ready in write txn", {7'd0, wr_ready}, 8'h01);
    tick();
    wr_valid = 1'b0;
  endtask

  task automatic do_r(input logic [7:0] exp, input string tag);
    rd_ready = 1'b1;
    #1;
    chk("R4", "rd_valid in read txn", {7'd0, rd_valid}, 8'h01);
    chk(tag, "read byte", rd_data, exp);
    tick();
    rd_ready = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    tick(); tick();
    rst_n = 1'b1;
    #1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired (all requirements)");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    do_reset();
    // R1: reset state
    chk("R1", "wr_ready after reset", {7'd0, wr_ready}, 8'h00);
    chk("R1", "rd_valid after reset", {7'd0, rd_valid}, 8'h00);
    chk("R1", "mem_ctrl after reset", mem_ctrl, 8'h00);
    chk("R1", "byte at pointer 0 after reset", rd_data, 8'h00);

    // R11: byte offered while idle is not taken
    wr_valid = 1'b1; wr_data = 8'h5C;
    #1;
    chk("R11", "wr_ready while idle", {7'd0, wr_ready}, 8'h00);
    tick();
    wr_valid = 1'b0;

    for (int k = 0; k < NVEC; k++) begin
      logic [2:0] op;
      logic [7:0] d;
      string tg;
      op = VEC[k][14:12];
      d  = VEC[k][11:4];
      tg = tag_name(VEC[k][3:0]);
      case (op)
        OP_SW:   do_start(1'b0);
        OP_SR:   do_start(1'b1);
        OP_W:    do_w(d, tg);
        OP_R:    do_r(d, tg);
        default: do_stop();
      endcase
    end
    chk("R6", "mem_ctrl keeps lock after clear attempt", mem_ctrl, 8'h45);

    // R10: saturation at 0xFF, no wrap to the control byte
    do_start(1'b0); do_w(8'hFE, "R2"); do_w(8'h12, "R9"); do_w(8'h34, "R10"); do_stop();
    do_start(1'b1); do_r(8'h00, "R10"); do_r(8'h00, "R10"); do_stop();
    // R9: reserved write discarded
    do_start(1'b0); do_w(8'hFE, "R2"); do_stop();
    do_start(1'b1); do_r(8'h00, "R9"); do_stop();

    // R4: back-pressure holds byte and pointer
    do_start(1'b0); do_w(8'h09, "R2"); do_stop();
    do_start(1'b1);
    for (int s = 0; s < 4; s++) begin
      #1;
      chk("R4", "held byte under back-pressure", rd_data, 8'hC3);
      tick();
    end
    do_r(8'hC3, "R4"); do_r(8'h5A, "R4");
    do_stop();

    // R1 and R6: reset clears lock and serial, then serial writable again
    do_reset();
    chk("R1", "mem_ctrl cleared by reset", mem_ctrl, 8'h00);
    do_start(1'b0); do_w(8'h01, "R2"); do_stop();
    do_start(1'b1); do_r(8'h00, "R1"); do_stop();
    do_start(1'b0); do_w(8'h08, "R2"); do_w(8'hE7, "R7"); do_stop();
    do_start(1'b0); do_w(8'h08, "R2"); do_stop();
    do_start(1'b1); do_r(8'hE7, "R7"); do_r(8'hC3, "R8"); do_stop();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule